// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block gathers event pulses from a transmit DMA sequencer and a receive DMA sequencer into one 32-bit status word. Each event lane has a fixed bit position. An event lane sets its bit, and the bit stays set until software clears it by writing a one to it. The word also carries two derived summary bits. One summary covers ordinary completion and buffer events. The other covers error and stop conditions. Three read-only fields in the same word show, live, the current transmit state code, the current receive state code and the bus-error type.

A single interrupt line leaves the block. It is raised when either summary is set and its enable is on. The register port is a plain write strobe with write data and an always-valid read word. Address decode is done outside the block, so this block only sees strobes that are aimed at it. The block has no data stream, so every pin is a plain control or status signal and none has back-pressure.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every event bit and both summary bits read 0, and `irq_o` is low.
- R2: A 1 on event lane k (k in 0,1,2,3,5,6,7,8,9,13) sets status bit k at the next clock edge. The bit then stays 1 on later cycles until it is cleared.
- R3: A write with `wr_en_i` high clears every event bit whose `wr_data_i` bit is 1, at that edge. Event bits written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is 1 after the edge.
- R5: Bit 16, the normal summary, reads as the OR of bits 0, 2 and 6.
- R6: Bit 15, the abnormal summary, reads as the OR of bits 1, 3, 5, 7, 8, 9 and 13.
- R7: Bits 19:17 show `rx_state_i`, bits 22:20 show `tx_state_i` and bits 25:23 show `berr_type_i`, all in the same cycle. Writes to these bits have no effect.
- R8: Bits 4, 12:10, 14 and 31:26 always read 0. Pulses on event lanes 4, 10, 11 and 12 set nothing.
- R9: `irq_o` equals (bit 16 AND `irq_en_i[0]`) OR (bit 15 AND `irq_en_i[1]`), in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 14 | Event pulses, lane k aims at status bit k |
| tx_state_i | input | 3 | Current transmit sequencer state code |
| rx_state_i | input | 3 | Current receive sequencer state code |
| berr_type_i | input | 3 | Type code of the last bus error |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data, a 1 clears the matching event bit |
| rd_data_o | output | 32 | Status word |
| irq_en_i | input | 2 | Bit 0 enables the normal summary, bit 1 the abnormal summary |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing write that lands on exactly the cycle in which the same lane pulses. The lane must also be set already, so that a wrong priority becomes visible. The stimulus first sets chosen lanes. It then issues a write of all ones together with a pulse on some of those lanes. Random traffic follows, with a dense write rate so that such collisions keep happening. A behavioural model of the word is compared with the design on every cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int WORD_W   = 32;
  localparam int EV_W     = 14;
  localparam int ST_W     = 3;
  localparam int AIS_BIT  = 15;
  localparam int NIS_BIT  = 16;
  localparam int RXST_LSB = 17;
  localparam int TXST_LSB = RXST_LSB + ST_W;
  localparam int BERR_LSB = TXST_LSB + ST_W;
  localparam int TOP_LSB  = BERR_LSB + ST_W;
  // lanes feeding the normal summary: 0, 2, 6
  localparam logic [EV_W-1:0] NORM_MASK = 14'h0045;
  // lanes feeding the abnormal summary: 1, 3, 5, 7, 8, 9, 13
  localparam logic [EV_W-1:0] ABN_MASK  = 14'h23AA;
  localparam logic [EV_W-1:0] LIVE_MASK = NORM_MASK | ABN_MASK;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 14,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_lane
    if (MASK[k]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_q <= 1'b0;
        else if (set_i[k]) bit_q <= 1'b1;
        else if (clr_i[k]) bit_q <= 1'b0;
      end
      assign q_o[k] = bit_q;

      // R2
      set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k] |=> q_o[k]);
      // R2
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[k] && !clr_i[k]) |=> q_o[k]);
      // R3
      clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && !set_i[k]) |=> !q_o[k]);
      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && set_i[k]) |=> q_o[k]);
    end else begin : g_rsvd
      assign q_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int W = 14,
  parameter logic [W-1:0] NMASK = '0,
  parameter logic [W-1:0] AMASK = '0
) (
  input  logic [W-1:0] q_i,
  input  logic [1:0]   en_i,
  output logic         nis_o,
  output logic         ais_o,
  output logic         irq_o
);
  always_comb begin
    nis_o = |(q_i & NMASK);
    ais_o = |(q_i & AMASK);
    irq_o = (nis_o & en_i[0]) | (ais_o & en_i[1]);
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_W-1:0]   ev_i,
  input  logic [ST_W-1:0]   tx_state_i,
  input  logic [ST_W-1:0]   rx_state_i,
  input  logic [ST_W-1:0]   berr_type_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [1:0]        irq_en_i,
  output logic              irq_o
);
  logic [EV_W-1:0] clr_w, ev_q;
  logic            nis_w, ais_w;

  assign clr_w = wr_en_i ? wr_data_i[EV_W-1:0] : '0;

  irq_sticky_bank #(.W(EV_W), .MASK(LIVE_MASK)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_i(ev_i), .clr_i(clr_w), .q_o(ev_q));

  irq_summary #(.W(EV_W), .NMASK(NORM_MASK), .AMASK(ABN_MASK)) sum_i (
    .q_i(ev_q), .en_i(irq_en_i), .nis_o(nis_w), .ais_o(ais_w), .irq_o(irq_o));

  always_comb begin
    rd_data_o = '0;
    rd_data_o[EV_W-1:0] = ev_q;
    rd_data_o[AIS_BIT]  = ais_w;
    rd_data_o[NIS_BIT]  = nis_w;
    rd_data_o[RXST_LSB +: ST_W] = rx_state_i;
    rd_data_o[TXST_LSB +: ST_W] = tx_state_i;
    rd_data_o[BERR_LSB +: ST_W] = berr_type_i;
  end

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[WORD_W-1:TOP_LSB] == '0) && !rd_data_o[14] &&
    (rd_data_o[12:10] == 3'b0) && !rd_data_o[4]);
  // R5
  nis_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[NIS_BIT] == (rd_data_o[0] | rd_data_o[2] | rd_data_o[6]));
  // R6
  ais_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[AIS_BIT] == (|{rd_data_o[1], rd_data_o[3], rd_data_o[5],
                             rd_data_o[7], rd_data_o[8], rd_data_o[9], rd_data_o[13]}));
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((rd_data_o[NIS_BIT] && irq_en_i[0]) || (rd_data_o[AIS_BIT] && irq_en_i[1])));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && rd_data_o[NIS_BIT:0] == '0));
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ev = '0;
  logic [2:0]  txs = '0, rxs = '0, bet = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [1:0]  en = '0;
  logic        irq;

  int errors = 0, checks = 0, cycles = 0;
  bit model_q [14];

  always #4 clk = ~clk;

  dma_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .tx_state_i(txs), .rx_state_i(rxs),
    .berr_type_i(bet), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd),
    .irq_en_i(en), .irq_o(irq));

  function automatic bit lane_live(int k);
    return (k == 0 || k == 1 || k == 2 || k == 3 || k == 5 || k == 6 ||
            k == 7 || k == 8 || k == 9 || k == 13);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [13:0] e;
    bit nis, ais, ir;
    e = '0;
    for (int k = 0; k < 14; k++) e[k] = model_q[k];
    nis = model_q[0] | model_q[2] | model_q[6];
    ais = model_q[1] | model_q[3] | model_q[5] | model_q[7] |
          model_q[8] | model_q[9] | model_q[13];
    ir = (nis && en[0]) || (ais && en[1]);
    chk("R2/R3/R4 event bits", {18'b0, rd[13:0]}, {18'b0, e});
    chk("R5 normal summary", {31'b0, rd[16]}, {31'b0, nis});
    chk("R6 abnormal summary", {31'b0, rd[15]}, {31'b0, ais});
    chk("R7 state fields", {23'b0, rd[25:17]}, {23'b0, bet, txs, rxs});
    chk("R8 reserved bits", {rd[31:26], rd[14], rd[12:10], rd[4]}, 32'b0);
    chk("R9 irq", {31'b0, irq}, {31'b0, ir});
  endtask

  // drive at negedge, compare, then advance the model across the edge
  task automatic step(logic [13:0] e, bit w, logic [31:0] d, logic [1:0] m);
    @(negedge clk);
    ev = e; wr = w; wd = d; en = m;
    txs = 3'($urandom); rxs = 3'($urandom); bet = 3'($urandom);
    #1 compare();
    @(posedge clk);
    for (int k = 0; k < 14; k++) begin
      if (!lane_live(k)) continue;
      if (e[k]) model_q[k] = 1'b1;
      else if (w && d[k]) model_q[k] = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    for (int k = 0; k < 14; k++) model_q[k] = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R1 reset word", {rd[31:26], rd[16:0], 9'b0}, 32'b0);
    chk("R1 reset irq", {31'b0, irq}, 32'b0);
    @(negedge clk) rst_n = 1'b1;
    // R2: each lane alone, then R3 clear it
    for (int k = 0; k < 14; k++) begin
      step(14'(1 << k), 1'b0, 32'b0, 2'b11);
      step('0, 1'b0, 32'b0, 2'b11);
      step('0, 1'b1, 32'b0, 2'b11);             // R3 zero write ignored
      step('0, 1'b1, 32'(1 << k), 2'b11);
    end
    // R8 reserved lanes only
    step(14'h1C10, 1'b0, 32'b0, 2'b11);
    // R4 collision on set bits
    step(14'h23EF, 1'b0, 32'b0, 2'b01);
    step(14'h2041, 1'b1, 32'hFFFF_FFFF, 2'b10);
    step('0, 1'b0, 32'b0, 2'b00);
    // R7 write to state fields ignored
    step('0, 1'b1, 32'h03FE_0000, 2'b01);
    // R9 enable combinations, random traffic
    for (int i = 0; i < 1500; i++)
      step(($urandom % 3 == 0) ? 14'($urandom) : 14'(1 << ($urandom % 14)),
           ($urandom % 2) == 1, $urandom, 2'($urandom));
    step('0, 1'b0, 32'b0, 2'b11);
    finish_run();
  end
endmodule